// File: doc/BRIEF.md
# Split-Bus Packed Integer Execution Unit

This block executes packed integer add-type operations on either 64-bit or 128-bit operands. It has two identical 64-bit lanes, and each lane holds an operation for two clocks. An operand is passed to the lanes over a bus that is one lane wide. A 128-bit operation therefore has its low half start in a free lane, and its high half starts on the next clock in the other lane. A 64-bit operation takes whichever lane is free, so independent 64-bit work sustains one operation per clock. The halves of wide operations can interleave with narrow operations.

A dependency flag comes with each issue. It marks an operation that consumes the result of the most recent accepted operation of the same width. Because dependence is tracked per half, a wide consumer may start its low half as soon as the producer's low half has finished. The high half of the producer may still be in flight at that point. A free-running cycle counter output lets a bench measure completion times against the issue stream.

Top module: `simd_split_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `issueReady` is 1, `resultValid` is 0 and `cycleCount` is 0.
- R2: `issueOp` encodings are as follows. 0 adds 64-bit elements. 1 subtracts 64-bit elements (A minus B). 2 adds 32-bit elements. 3 adds 16-bit elements. Every element wraps modulo its width, and no carry crosses an element boundary. A 128-bit operation applies the same operation to bits 63:0 and to bits 127:64 independently.
- R3: A 64-bit operation (`issueWide`=0) accepted in cycle c shows `resultValid`=1, `resultWide`=0 and its result on bits 63:0 in cycle c+2. Bits 127:64 are zero.
- R4: A 128-bit operation accepted in cycle c shows `resultValid`=1 and `resultWide`=1 with both halves in cycle c+3. It shows no earlier result, so a low half alone is never flagged complete.
- R5: In the cycle after a 128-bit operation is accepted, `issueReady` is 0, because the bus is carrying that operation's high half.
- R6: A lane started in cycle c cannot start again in cycle c+1. A new operation is accepted when either lane is free. Independent 64-bit operations are therefore accepted on consecutive cycles.
- R7: With `issueDep`=1, an operation is accepted no earlier than 2 cycles after the most recent accepted operation of the same width.
- R8: Consider n 128-bit operations alternating with n dependent 64-bit operations, issued back to back. The last result appears 3n+1 cycles after the first acceptance, which means 3 clocks per pair.
- R9: Consider a chain of n dependent 128-bit operations. The last result appears 2n+1 cycles after the first acceptance: 2 clocks per link, plus one clock for the final high half.
- R10: `cycleCount` increments by one every clock after reset and wraps modulo 2^CNT_W.
- R11: While `issueReady` is 0, holding `issueValid` accepts nothing. Each operation is accepted exactly once and yields exactly one result, with results in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue request |
| issueReady | output | 1 | Request accepted this cycle when high together with issueValid |
| issueWide | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| issueOp | input | 2 | Operation encoding (R2) |
| issueDep | input | 1 | Depends on the last accepted operation of the same width |
| issueA | input | 2*HALF_W | First operand |
| issueB | input | 2*HALF_W | Second operand |
| resultValid | output | 1 | Completed result present |
| resultWide | output | 1 | Completed result is 128-bit |
| resultData | output | 2*HALF_W | Result value |
| cycleCount | output | CNT_W | Free-running clock counter |

## Verification
The bench keeps HALF_W at 64, so both packed element sizes fit several times per half and carry isolation is visible. It sets CNT_W to 8 so the counter wraps within a run of a few hundred clocks. A behavioural model tracks lane start times, the pending high half and per-width producer times. It predicts `issueReady` and every result on every clock. Dedicated sequences measure the 3n+1 and 2n+1 spans, the one-per-clock narrow stream and the stall after each wide issue.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

  typedef enum logic [1:0] {
    OP_ADD64 = 2'd0,
    OP_SUB64 = 2'd1,
    OP_ADD32 = 2'd2,
    OP_ADD16 = 2'd3
  } simdOp_e;

  // strobes from control to datapath, one bit per lane
  typedef struct packed {
    logic [1:0] start;
    logic [1:0] useHigh;
    logic [1:0] isWide;
    logic [1:0] isHigh;
    logic       latchHigh;
  } laneCtl_t;

endpackage

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
module simd_lane #(
  parameter int HALF_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  input  logic              isWide,
  input  logic              isHigh,
  output logic              doneV,
  output logic              doneWide,
  output logic              doneHigh,
  output logic [HALF_W-1:0] res
);
  import simd_pkg::*;
  localparam int N32 = HALF_W / 32;
  localparam int N16 = HALF_W / 16;

  logic              holdV, holdWide, holdHigh;
  logic [1:0]        holdOp;
  logic [HALF_W-1:0] holdA, holdB, sum;

  always_comb begin
    sum = '0;
    case (simdOp_e'(holdOp))
      OP_ADD64: sum = holdA + holdB;
      OP_SUB64: sum = holdA - holdB;
      OP_ADD32: for (int k = 0; k < N32; k++)
                  sum[k*32 +: 32] = holdA[k*32 +: 32] + holdB[k*32 +: 32];
      default:  for (int k = 0; k < N16; k++)
                  sum[k*16 +: 16] = holdA[k*16 +: 16] + holdB[k*16 +: 16];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdV <= 1'b0; holdWide <= 1'b0; holdHigh <= 1'b0; holdOp <= '0;
      holdA <= '0; holdB <= '0;
      doneV <= 1'b0; doneWide <= 1'b0; doneHigh <= 1'b0; res <= '0;
    end else begin
      holdV <= start;
      if (start) begin
        holdA <= a; holdB <= b; holdOp <= op;
        holdWide <= isWide; holdHigh <= isHigh;
      end
      doneV <= holdV;
      if (holdV) begin
        res <= sum; doneWide <= holdWide; doneHigh <= holdHigh;
      end
    end
  end

  // half-speed lane: never restarted on the following clock
  assert_lane_rate_R6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !start);

endmodule

// File: rtl/simd_ctrl.sv
`timescale 1ns/1ps
module simd_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic                  issueWide,
  input  logic                  issueDep,
  output logic                  issueReady,
  output simd_pkg::laneCtl_t    ctl,
  output logic [CNT_W-1:0]      cycleCount
);
  import simd_pkg::*;

  logic [1:0] laneBusy;
  logic       highPend, highLane;
  logic [1:0] ageNarrow, ageWide, depAge;
  logic       depOk, accept, lowLane;

  always_comb begin
    depAge     = issueWide ? ageWide : ageNarrow;
    depOk      = !issueDep || (depAge >= 2'd2);
    issueReady = !highPend && (!laneBusy[0] || !laneBusy[1]) && depOk;
    accept     = issueValid && issueReady;
    lowLane    = laneBusy[0];
    ctl        = '0;
    if (accept) begin
      ctl.start[lowLane]  = 1'b1;
      ctl.isWide[lowLane] = issueWide;
      ctl.latchHigh       = issueWide;
    end
    if (highPend) begin
      ctl.start[highLane]   = 1'b1;
      ctl.useHigh[highLane] = 1'b1;
      ctl.isWide[highLane]  = 1'b1;
      ctl.isHigh[highLane]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneBusy <= '0; highPend <= 1'b0; highLane <= 1'b0;
      ageNarrow <= 2'd3; ageWide <= 2'd3; cycleCount <= '0;
    end else begin
      laneBusy   <= ctl.start;
      highPend   <= accept && issueWide;
      highLane   <= !lowLane;
      cycleCount <= cycleCount + 1'b1;
      if (accept && !issueWide)    ageNarrow <= 2'd1;
      else if (ageNarrow != 2'd3)  ageNarrow <= ageNarrow + 2'd1;
      if (accept && issueWide)     ageWide <= 2'd1;
      else if (ageWide != 2'd3)    ageWide <= ageWide + 2'd1;
    end
  end

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cycleCount == $past(cycleCount) + 1'b1);

  assert_dep_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && !issueWide) |=>
      !(issueValid && issueReady && !issueWide && issueDep));

endmodule

// File: rtl/simd_datapath.sv
`timescale 1ns/1ps
module simd_datapath #(
  parameter int HALF_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  simd_pkg::laneCtl_t    ctl,
  input  logic [1:0]            issueOp,
  input  logic [2*HALF_W-1:0]   issueA,
  input  logic [2*HALF_W-1:0]   issueB,
  output logic                  resultValid,
  output logic                  resultWide,
  output logic [2*HALF_W-1:0]   resultData
);
  localparam int WIDE_W = 2 * HALF_W;

  logic [HALF_W-1:0] hiA, hiB, loHold;
  logic [1:0]        hiOp;
  logic [1:0]        laneDone, laneWide, laneHigh;
  logic [HALF_W-1:0] laneRes [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiA <= '0; hiB <= '0; hiOp <= '0; loHold <= '0;
    end else begin
      if (ctl.latchHigh) begin
        hiA <= issueA[WIDE_W-1:HALF_W];
        hiB <= issueB[WIDE_W-1:HALF_W];
        hiOp <= issueOp;
      end
      for (int i = 0; i < 2; i++)
        if (laneDone[i] && laneWide[i] && !laneHigh[i]) loHold <= laneRes[i];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gLane
    simd_lane #(.HALF_W(HALF_W)) uLane (
      .clk(clk), .rstN(rstN),
      .start(ctl.start[g]),
      .op(ctl.useHigh[g] ? hiOp : issueOp),
      .a(ctl.useHigh[g] ? hiA : issueA[HALF_W-1:0]),
      .b(ctl.useHigh[g] ? hiB : issueB[HALF_W-1:0]),
      .isWide(ctl.isWide[g]), .isHigh(ctl.isHigh[g]),
      .doneV(laneDone[g]), .doneWide(laneWide[g]), .doneHigh(laneHigh[g]),
      .res(laneRes[g])
    );

    // a high half always finishes one clock after the other lane's low half
    assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
      (laneDone[g] && laneHigh[g]) |->
        $past(laneDone[1-g] && laneWide[1-g] && !laneHigh[1-g]));
  end

  always_comb begin
    logic sel;
    sel         = !laneDone[0];
    resultValid = laneDone[sel] && (!laneWide[sel] || laneHigh[sel]);
    resultWide  = laneWide[sel] && laneDone[sel];
    resultData  = resultWide ? {laneRes[sel], loHold}
                             : {{HALF_W{1'b0}}, laneRes[sel]};
  end

  assert_one_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(laneDone[0] && laneDone[1]));

endmodule

// File: rtl/simd_split_unit.sv
`timescale 1ns/1ps
module simd_split_unit #(
  parameter int HALF_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  output logic                issueReady,
  input  logic                issueWide,
  input  logic [1:0]          issueOp,
  input  logic                issueDep,
  input  logic [2*HALF_W-1:0] issueA,
  input  logic [2*HALF_W-1:0] issueB,
  output logic                resultValid,
  output logic                resultWide,
  output logic [2*HALF_W-1:0] resultData,
  output logic [CNT_W-1:0]    cycleCount
);
  simd_pkg::laneCtl_t ctl;

  simd_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueWide(issueWide),
    .issueDep(issueDep), .issueReady(issueReady), .ctl(ctl),
    .cycleCount(cycleCount)
  );

  simd_datapath #(.HALF_W(HALF_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .issueOp(issueOp),
    .issueA(issueA), .issueB(issueB), .resultValid(resultValid),
    .resultWide(resultWide), .resultData(resultData)
  );

  assert_narrow_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && !issueWide) |=> ##1 (resultValid && !resultWide));

  assert_wide_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && issueWide) |=> ##2 (resultValid && resultWide));

  assert_bus_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && issueWide) |=> !issueReady);

endmodule

// File: tb/sim_simd_split_unit.sv
`timescale 1ns/1ps
module sim_simd_split_unit;
  localparam int HALF_W = 64;
  localparam int CNT_W  = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         issueValid = 1'b0, issueWide = 1'b0, issueDep = 1'b0;
  logic [1:0]   issueOp = '0;
  logic [127:0] issueA = '0, issueB = '0;
  logic         issueReady, resultValid, resultWide;
  logic [127:0] resultData;
  logic [CNT_W-1:0] cycleCount;

  simd_split_unit #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
    .issueWide(issueWide), .issueOp(issueOp), .issueDep(issueDep),
    .issueA(issueA), .issueB(issueB), .resultValid(resultValid),
    .resultWide(resultWide), .resultData(resultData), .cycleCount(cycleCount)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int laneStart [2] = '{-10, -10};
  int lastWideAcc = -10, lastNarrow = -10, lastWideStart = -10;
  int qDue[$];
  logic [127:0] qDat[$];
  bit qWide[$];
  bit acceptedNow = 0;
  int firstAcc = -1, lastRes = -1, resCount = 0;
  bit doneFlag = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] refHalf(int op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0, mask, x;
    int esz;
    if (op == 1) return a - b;
    esz  = (op == 0) ? 64 : (op == 2) ? 32 : 16;
    mask = (esz == 64) ? '1 : ((64'd1 << esz) - 1);
    for (int e = 0; e < 64 / esz; e++) begin
      x = ((a >> (e * esz)) & mask) + ((b >> (e * esz)) & mask);
      r |= (x & mask) << (e * esz);
    end
    return r;
  endfunction

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // behavioural model, evaluated mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      bit free0, free1, pend, depOk, expReady, acc;
      logic [127:0] expD;
      free0 = (laneStart[0] != cyc - 1);
      free1 = (laneStart[1] != cyc - 1);
      pend  = (lastWideAcc == cyc - 1);
      depOk = !issueDep || (cyc - (issueWide ? lastWideStart : lastNarrow) >= 2);
      expReady = !pend && (free0 || free1) && depOk;
      chk(issueReady == expReady, "R5/R6/R7", "issueReady", 128'(issueReady), 128'(expReady));
      chk(cycleCount == CNT_W'(cyc), "R10", "cycleCount", 128'(cycleCount), 128'(CNT_W'(cyc)));
      if (qDue.size() > 0 && qDue[0] == cyc) begin
        chk(resultValid === 1'b1, "R3/R4", "resultValid", 128'(resultValid), 128'(1));
        chk(resultWide == qWide[0], "R3/R4", "resultWide", 128'(resultWide), 128'(qWide[0]));
        chk(resultData == qDat[0], "R2", "resultData", resultData, qDat[0]);
        void'(qDue.pop_front()); void'(qDat.pop_front()); void'(qWide.pop_front());
      end else begin
        chk(resultValid === 1'b0, "R4/R11", "resultValid idle", 128'(resultValid), 128'(0));
      end
      if (resultValid) begin lastRes = cyc; resCount++; end
      acc = issueValid && expReady;
      acceptedNow = acc;
      if (acc) begin
        int ln;
        ln = free0 ? 0 : 1;
        laneStart[ln] = cyc;
        if (firstAcc < 0) firstAcc = cyc;
        expD[63:0]   = refHalf(int'(issueOp), issueA[63:0], issueB[63:0]);
        expD[127:64] = issueWide ? refHalf(int'(issueOp), issueA[127:64], issueB[127:64]) : 64'd0;
        if (issueWide) begin
          laneStart[1-ln] = cyc + 1;
          lastWideAcc = cyc; lastWideStart = cyc;
        end else lastNarrow = cyc;
        qDue.push_back(cyc + (issueWide ? 3 : 2));
        qDat.push_back(expD);
        qWide.push_back(issueWide);
      end
    end
  end

  task automatic doIssue(bit w, int op, bit d, logic [127:0] a, logic [127:0] b);
    issueValid = 1; issueWide = w; issueOp = 2'(op); issueDep = d;
    issueA = a; issueB = b;
    forever begin
      @(negedge clk); #0.1;
      if (acceptedNow) break;
    end
    @(posedge clk); #0.5;
    issueValid = 0; issueDep = 0;
  endtask

  task automatic drain();
    while (qDue.size() > 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #0.5;
  endtask

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!doneFlag) begin
      fails++;
      $display("FAIL R11 watchdog: actual %0d cycles expected completion", 5000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    chk(issueReady == 1'b1, "R1", "reset ready", 128'(issueReady), 128'(1));
    chk(resultValid == 1'b0, "R1", "reset resultValid", 128'(resultValid), 128'(0));
    chk(cycleCount == '0, "R1", "reset cycleCount", 128'(cycleCount), 128'(0));
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk); #0.5;

    // R2: every opcode with carry-crossing corners, both widths
    for (int op = 0; op < 4; op++) begin
      doIssue(0, op, 0, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'd0, 64'h0000_0001_0001_0001});
      doIssue(1, op, 0, {64'h8000_7FFF_FFFF_0000, 64'hFFFF_FFFF_0000_FFFF},
                        {64'h8000_0001_0001_0001, 64'h0000_0001_FFFF_0002});
    end
    for (int i = 0; i < 8; i++) doIssue(i[0], i % 4, 0, rnd(), rnd());
    drain();

    // R6: independent narrow stream, one per clock
    firstAcc = -1;
    for (int i = 0; i < 6; i++) doIssue(0, i % 4, 0, rnd(), rnd());
    drain();
    chk(lastRes - firstAcc == 7, "R6", "narrow stream span", 128'(lastRes - firstAcc), 128'(7));

    // R7: dependent narrow chain, 2 clocks per link
    firstAcc = -1;
    for (int i = 0; i < 4; i++) doIssue(0, 0, 1, rnd(), rnd());
    drain();
    chk(lastRes - firstAcc == 8, "R7", "narrow chain span", 128'(lastRes - firstAcc), 128'(8));

    // R8: wide alternating with dependent narrow
    firstAcc = -1;
    for (int i = 0; i < 4; i++) begin
      doIssue(1, 2, 0, rnd(), rnd());
      doIssue(0, 3, 1, rnd(), rnd());
    end
    drain();
    chk(lastRes - firstAcc == 13, "R8", "alternating span", 128'(lastRes - firstAcc), 128'(13));

    // R9: dependent wide chain
    firstAcc = -1;
    for (int i = 0; i < 4; i++) doIssue(1, 1, 1, rnd(), rnd());
    drain();
    chk(lastRes - firstAcc == 9, "R9", "wide chain span", 128'(lastRes - firstAcc), 128'(9));

    // R11: stall after wide issue, one result per operation
    resCount = 0;
    doIssue(1, 0, 0, rnd(), rnd());
    doIssue(0, 1, 0, rnd(), rnd());
    doIssue(1, 3, 0, rnd(), rnd());
    doIssue(1, 2, 0, rnd(), rnd());
    drain();
    chk(resCount == 4, "R11", "result count", 128'(resCount), 128'(4));

    // R10: run past counter wrap
    while (cyc < 300) @(posedge clk);
    #0.5;
    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule